// File: doc/BRIEF.md
# Lock-Step Bus Compare Monitor

This block sits between two processor cores that run the same instruction stream in strict cycle synchronization and the rest of the chip. The master core's bus, meaning its address, write data, valid, write-enable and output strobe, is forwarded to memory and the system outputs. The checker core's bus goes nowhere except into the comparator. Both bundles are registered, and every duplicated line is compared. Any disagreement raises a sticky error flag one cycle later. The block does not try to tell which core diverged.

Both cores see read data from shared memory identically, so a corruption on that path would not show up as a core disagreement. For this reason the block also checks a parity bit that travels with every valid read. On any fault the node goes fail-silent. The write and output strobes are held low from the divergent cycle onward until reset.

Top module: `lockstep_cmp_monitor`

## Requirements
- R1: The bus outputs repeat the master's address, write data and valid exactly two clock edges after they are applied. Checker values never appear on the bus outputs.
- R2: The three control lines (valid, write-enable, output strobe) are compared in every cycle. A difference on any one of them is a fault.
- R3: The address lines are compared only in cycles where either core asserts valid. Address differences in cycles where both valids are low are ignored.
- R4: The write-data lines are compared only in cycles where either core asserts write-enable. Write-data differences in cycles where both write-enables are low are ignored.
- R5: With the default parity setting, a read with `rd_valid` high is a fault unless `rd_data` and `rd_par` together hold an even number of ones. Parity is ignored while `rd_valid` is low.
- R6: A fault applied before clock edge k leaves `err_flag` low after edge k and sets it after edge k+1.
- R7: `err_flag` is sticky. Once set, it stays high until `rst` is asserted, whatever the inputs do.
- R8: `out_inhibit` follows `err_flag`. While it is high, `bus_we` and `bus_ostb` are low. The strobes of the divergent cycle itself are also suppressed at the bus outputs.
- R9: After a synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_addr | input | AW | Master core address |
| mst_wdata | input | DW | Master core write data |
| mst_valid | input | 1 | Master bus cycle valid |
| mst_we | input | 1 | Master write enable |
| mst_ostb | input | 1 | Master system-output strobe |
| chk_addr | input | AW | Checker core address |
| chk_wdata | input | DW | Checker core write data |
| chk_valid | input | 1 | Checker bus cycle valid |
| chk_we | input | 1 | Checker write enable |
| chk_ostb | input | 1 | Checker system-output strobe |
| rd_data | input | DW | Shared read data from memory |
| rd_par | input | 1 | Parity bit carried with read data |
| rd_valid | input | 1 | Read data is valid this cycle |
| bus_addr | output | AW | Forwarded master address |
| bus_wdata | output | DW | Forwarded master write data |
| bus_valid | output | 1 | Forwarded master valid |
| bus_we | output | 1 | Forwarded write enable, gated by fault |
| bus_ostb | output | 1 | Forwarded output strobe, gated by fault |
| err_flag | output | 1 | Sticky fault flag |
| out_inhibit | output | 1 | Fail-silent indication |

## Verification
Each address bit and each write-data bit is flipped on its own, once with its qualifying control line asserted and once with it deasserted. This separates lines that are really compared from lines that are correctly ignored while idle. Each control line is flipped alone to show that control is compared unconditionally. All read-data values are tried with correct parity, with flipped parity, and with flipped parity but no valid read, which separates the parity check from its qualifier. Matching bundles over a range of values show that no false fault occurs and that only master values reach the bus. After a fault, matching write cycles show that the flag stays set and the strobes stay silenced.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  // Bit positions of the fault cause vector
  localparam int unsigned CAUSE_CTRL = 0;
  localparam int unsigned CAUSE_ADDR = 1;
  localparam int unsigned CAUSE_DATA = 2;
  localparam int unsigned CAUSE_PAR  = 3;
  localparam int unsigned NUM_CAUSE  = 4;
  // Number of control lines per bundle: valid, write enable, output strobe
  localparam int unsigned NUM_CTRL   = 3;
endpackage

// File: rtl/lsm_capture.sv
module lsm_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/lsm_parity_chk.sv
module lsm_parity_chk #(
  parameter int unsigned DW      = 32,
  parameter bit          ODD_PAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data,
  input  logic          par,
  input  logic          valid,
  output logic          par_err
);
  logic ones_odd;
  assign ones_odd = ^{data, par};

  generate
    if (ODD_PAR) begin : g_odd
      assign par_err = valid & ~ones_odd;
    end else begin : g_even
      assign par_err = valid & ones_odd;
    end
  endgenerate

  // R5: no parity fault is reported without a valid read
  p_par_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
    par_err |-> valid);
endmodule

// File: rtl/lsm_compare.sv
module lsm_compare #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 m_addr,
  input  logic [DW-1:0]                 m_wdata,
  input  logic [lsm_pkg::NUM_CTRL-1:0]  m_ctrl,
  input  logic [AW-1:0]                 c_addr,
  input  logic [DW-1:0]                 c_wdata,
  input  logic [lsm_pkg::NUM_CTRL-1:0]  c_ctrl,
  output logic                          ctrl_mis,
  output logic                          addr_mis,
  output logic                          data_mis
);
  // ctrl bit order: [0] valid, [1] write enable, [2] output strobe
  localparam int unsigned NC = lsm_pkg::NUM_CTRL;

  logic [NC-1:0] ctrl_diff;
  logic [AW-1:0] addr_diff;
  logic [DW-1:0] data_diff;
  logic          addr_qual;
  logic          data_qual;

  genvar gi;
  generate
    for (gi = 0; gi < NC; gi++) begin : g_ctrl
      assign ctrl_diff[gi] = m_ctrl[gi] ^ c_ctrl[gi];
    end
    for (gi = 0; gi < AW; gi++) begin : g_addr
      assign addr_diff[gi] = m_addr[gi] ^ c_addr[gi];
    end
    for (gi = 0; gi < DW; gi++) begin : g_data
      assign data_diff[gi] = m_wdata[gi] ^ c_wdata[gi];
    end
  endgenerate

  assign addr_qual = m_ctrl[0] | c_ctrl[0];
  assign data_qual = m_ctrl[1] | c_ctrl[1];

  assign ctrl_mis = |ctrl_diff;
  assign addr_mis = addr_qual & (|addr_diff);
  assign data_mis = data_qual & (|data_diff);

  // R3: an address mismatch is only flagged in a qualified cycle
  p_addr_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    addr_mis |-> (m_ctrl[0] || c_ctrl[0]));
  // R4: a data mismatch is only flagged in a write cycle
  p_data_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    data_mis |-> (m_ctrl[1] || c_ctrl[1]));
  // R2: identical control lines never give a control mismatch
  p_ctrl_equal_r2: assert property (@(posedge clk) disable iff (rst)
    (m_ctrl == c_ctrl) |-> !ctrl_mis);
endmodule

// File: rtl/lsm_fault_gate.sv
module lsm_fault_gate #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  input  logic          s_valid,
  input  logic          s_we,
  input  logic          s_ostb,
  input  logic          fault_now,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_valid,
  output logic          bus_we,
  output logic          bus_ostb,
  output logic          err_flag,
  output logic          out_inhibit
);
  logic err_q;
  logic silence;

  assign silence = err_q | fault_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_ostb  <= 1'b0;
    end else begin
      err_q     <= silence;
      bus_addr  <= s_addr;
      bus_wdata <= s_wdata;
      bus_valid <= s_valid;
      bus_we    <= s_we & ~silence;
      bus_ostb  <= s_ostb & ~silence;
    end
  end

  assign err_flag    = err_q;
  assign out_inhibit = err_q;

  // R7: flag is sticky until reset
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R6: a fault seen at the compare stage sets the flag on the next edge
  p_flag_latency_r6: assert property (@(posedge clk) disable iff (rst)
    fault_now |=> err_flag);
  // R8: no strobe leaves while silenced
  p_inhibit_strobes_r8: assert property (@(posedge clk) disable iff (rst)
    out_inhibit |-> (!bus_we && !bus_ostb));
  // R1: forwarded address follows the stage register
  p_fwd_addr_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_addr == $past(s_addr)));
endmodule

// File: rtl/lockstep_cmp_monitor.sv
module lockstep_cmp_monitor #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter bit          ODD_PAR = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] mst_addr,
  input  logic [DW-1:0] mst_wdata,
  input  logic          mst_valid,
  input  logic          mst_we,
  input  logic          mst_ostb,
  input  logic [AW-1:0] chk_addr,
  input  logic [DW-1:0] chk_wdata,
  input  logic          chk_valid,
  input  logic          chk_we,
  input  logic          chk_ostb,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_par,
  input  logic          rd_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_valid,
  output logic          bus_we,
  output logic          bus_ostb,
  output logic          err_flag,
  output logic          out_inhibit
);
  import lsm_pkg::*;

  localparam int unsigned BW = AW + DW + NUM_CTRL;
  localparam int unsigned RW = DW + 2;

  logic [BW-1:0] m_in, c_in, m_s, c_s;
  logic [RW-1:0] r_in, r_s;

  // bundle layout: {ostb, we, valid, wdata, addr}
  assign m_in = {mst_ostb, mst_we, mst_valid, mst_wdata, mst_addr};
  assign c_in = {chk_ostb, chk_we, chk_valid, chk_wdata, chk_addr};
  assign r_in = {rd_valid, rd_par, rd_data};

  lsm_capture #(.W(BW)) u_cap_mst (.clk(clk), .rst(rst), .d(m_in), .q(m_s));
  lsm_capture #(.W(BW)) u_cap_chk (.clk(clk), .rst(rst), .d(c_in), .q(c_s));
  lsm_capture #(.W(RW)) u_cap_rd  (.clk(clk), .rst(rst), .d(r_in), .q(r_s));

  logic [NUM_CAUSE-1:0] cause;
  logic                 fault_now;

  lsm_compare #(.AW(AW), .DW(DW)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .m_addr   (m_s[AW-1:0]),
    .m_wdata  (m_s[AW +: DW]),
    .m_ctrl   (m_s[AW+DW +: NUM_CTRL]),
    .c_addr   (c_s[AW-1:0]),
    .c_wdata  (c_s[AW +: DW]),
    .c_ctrl   (c_s[AW+DW +: NUM_CTRL]),
    .ctrl_mis (cause[CAUSE_CTRL]),
    .addr_mis (cause[CAUSE_ADDR]),
    .data_mis (cause[CAUSE_DATA])
  );

  lsm_parity_chk #(.DW(DW), .ODD_PAR(ODD_PAR)) u_par (
    .clk     (clk),
    .rst     (rst),
    .data    (r_s[DW-1:0]),
    .par     (r_s[DW]),
    .valid   (r_s[DW+1]),
    .par_err (cause[CAUSE_PAR])
  );

  assign fault_now = |cause;

  lsm_fault_gate #(.AW(AW), .DW(DW)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .s_addr      (m_s[AW-1:0]),
    .s_wdata     (m_s[AW +: DW]),
    .s_valid     (m_s[AW+DW]),
    .s_we        (m_s[AW+DW+1]),
    .s_ostb      (m_s[AW+DW+2]),
    .fault_now   (fault_now),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_ostb    (bus_ostb),
    .err_flag    (err_flag),
    .out_inhibit (out_inhibit)
  );

  // R9: outputs low on the edge after reset
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!err_flag && !bus_we && !bus_ostb && !bus_valid));
endmodule

// File: tb/lockstep_cmp_monitor_bench.sv
module lockstep_cmp_monitor_bench;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mst_addr = '0, chk_addr = '0;
  logic [DW-1:0] mst_wdata = '0, chk_wdata = '0, rd_data = '0;
  logic          mst_valid = 0, mst_we = 0, mst_ostb = 0;
  logic          chk_valid = 0, chk_we = 0, chk_ostb = 0;
  logic          rd_par = 0, rd_valid = 0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_valid, bus_we, bus_ostb, err_flag, out_inhibit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  lockstep_cmp_monitor #(.AW(AW), .DW(DW), .ODD_PAR(1'b0)) u_lockstep_cmp_monitor (
    .clk(clk), .rst(rst),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_valid(mst_valid),
    .mst_we(mst_we), .mst_ostb(mst_ostb),
    .chk_addr(chk_addr), .chk_wdata(chk_wdata), .chk_valid(chk_valid),
    .chk_we(chk_we), .chk_ostb(chk_ostb),
    .rd_data(rd_data), .rd_par(rd_par), .rd_valid(rd_valid),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_ostb(bus_ostb),
    .err_flag(err_flag), .out_inhibit(out_inhibit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    mst_addr = '0; chk_addr = '0; mst_wdata = '0; chk_wdata = '0;
    mst_valid = 0; mst_we = 0; mst_ostb = 0;
    chk_valid = 0; chk_we = 0; chk_ostb = 0;
    rd_data = '0; rd_par = 0; rd_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle_inputs();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Apply one cycle, then check latency, forwarding and gating
  task automatic apply(
    input logic [AW-1:0] ma, input logic [DW-1:0] md,
    input logic mv, input logic mw, input logic mo,
    input logic [AW-1:0] ca, input logic [DW-1:0] cd,
    input logic cv, input logic cw, input logic co,
    input logic [DW-1:0] rdd, input logic rdp, input logic rdv,
    input logic exp_err, input string req);
    do_reset();
    mst_addr = ma; mst_wdata = md; mst_valid = mv; mst_we = mw; mst_ostb = mo;
    chk_addr = ca; chk_wdata = cd; chk_valid = cv; chk_we = cw; chk_ostb = co;
    rd_data = rdd; rd_par = rdp; rd_valid = rdv;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check({req, " R6 flag low after first edge"}, int'(err_flag), 0);
    @(posedge clk); @(negedge clk);
    check({req, " flag"}, int'(err_flag), int'(exp_err));
    check({req, " R8 inhibit"}, int'(out_inhibit), int'(exp_err));
    check({req, " R1 addr"}, int'(bus_addr), int'(ma));
    check({req, " R1 valid"}, int'(bus_valid), int'(mv));
    check({req, " R8 we gate"}, int'(bus_we), int'(mw & ~exp_err));
    check({req, " R8 ostb gate"}, int'(bus_ostb), int'(mo & ~exp_err));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R9: reset state
    do_reset();
    check("R9 err_flag", int'(err_flag), 0);
    check("R9 out_inhibit", int'(out_inhibit), 0);
    check("R9 bus_we", int'(bus_we), 0);
    check("R9 bus_valid", int'(bus_valid), 0);

    // R3: single address bit flips, qualified and idle
    for (int b = 0; b < AW; b++) begin
      logic [AW-1:0] a;
      a = 4'h5;
      apply(a, 4'h3, 1, 0, 0, a ^ (4'd1 << b), 4'h3, 1, 0, 0, '0, 0, 0, 1, "R3 addr flip valid");
      apply(a, 4'h3, 0, 0, 0, a ^ (4'd1 << b), 4'h3, 0, 0, 0, '0, 0, 0, 0, "R3 addr flip idle");
    end
    // R4: single write-data bit flips with and without write enable
    for (int b = 0; b < DW; b++) begin
      logic [DW-1:0] d;
      d = 4'hA;
      apply(4'h2, d, 1, 1, 0, 4'h2, d ^ (4'd1 << b), 1, 1, 0, '0, 0, 0, 1, "R4 data flip write");
      apply(4'h2, d, 1, 0, 0, 4'h2, d ^ (4'd1 << b), 1, 0, 0, '0, 0, 0, 0, "R4 data flip read");
    end
    // R2: each control line flipped alone
    apply(4'h1, 4'h0, 1, 0, 0, 4'h1, 4'h0, 0, 0, 0, '0, 0, 0, 1, "R2 valid flip");
    apply(4'h1, 4'h0, 1, 1, 0, 4'h1, 4'h0, 1, 0, 0, '0, 0, 0, 1, "R2 we flip");
    apply(4'h1, 4'h0, 0, 0, 1, 4'h1, 4'h0, 0, 0, 0, '0, 0, 0, 1, "R2 ostb flip");
    // R5: every read value with good, bad and unqualified parity
    for (int v = 0; v < 16; v++) begin
      logic [DW-1:0] rv;
      logic good;
      rv = 4'(v);
      good = ^rv;
      apply('0, '0, 0, 0, 0, '0, '0, 0, 0, 0, rv, good, 1, 0, "R5 good parity");
      apply('0, '0, 0, 0, 0, '0, '0, 0, 0, 0, rv, ~good, 1, 1, "R5 bad parity");
      apply('0, '0, 0, 0, 0, '0, '0, 0, 0, 0, rv, ~good, 0, 0, "R5 parity idle");
    end
    // R1: matching bundles forward master values, no false fault
    for (int v = 0; v < 16; v++) begin
      logic [3:0] x;
      x = 4'(v);
      apply(x, ~x, 1, x[0], x[1], x, ~x, 1, x[0], x[1], '0, 0, 0, 0, "R1 match");
    end
    // R1: checker data never reaches the bus
    do_reset();
    mst_wdata = 4'h6; chk_wdata = 4'h9; mst_addr = 4'hC; chk_addr = 4'h3;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    @(posedge clk); @(negedge clk);
    check("R1 wdata from master", int'(bus_wdata), 6);
    check("R1 idle addr from master", int'(bus_addr), 12);
    check("R3 idle addr no flag", int'(err_flag), 0);

    // R7 and R8: after a fault, matching writes stay silenced
    do_reset();
    mst_ostb = 1; chk_ostb = 0;
    @(posedge clk); @(negedge clk);
    mst_ostb = 1; chk_ostb = 1; mst_we = 1; chk_we = 1; mst_valid = 1; chk_valid = 1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (i >= 1) begin
        check("R7 flag sticky", int'(err_flag), 1);
        check("R8 we held low", int'(bus_we), 0);
        check("R8 ostb held low", int'(bus_ostb), 0);
      end
    end
    do_reset();
    check("R7 cleared by reset", int'(err_flag), 0);
    mst_we = 1; chk_we = 1; mst_valid = 1; chk_valid = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R8 we passes when healthy", int'(bus_we), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule